// File: doc/BRIEF.md
# Byte FIFO pair with programmable ready thresholds and flush

This block holds two small byte queues that sit between a 32-bit host register port and a serial shift engine. The transmit queue is filled by the host one 32-bit word (four bytes) at a time and drained by the shift engine one byte at a time. The receive queue is filled by the shift engine one byte at a time and drained by the host one word at a time. Words are little-endian: byte 0 of a host word is its least significant byte and is the first byte in queue order.

Each queue has a 3-bit threshold taken from the configuration word. The transmit queue reports ready when its free space exceeds its threshold. The receive queue reports ready when its fill level exceeds its threshold. Both queues report full and empty. Each queue keeps sticky error flags for a dropped push (overflow) and for a pop from an empty queue (underflow).

A one-cycle flush request empties both queues and clears all error flags. The flush indicator reads back as zero again once the flush has been done. A host word pop shows the oldest bytes on the read data port combinationally and removes them on the access. Byte lanes beyond the fill level read as zero.

Top module: `thr_fifo_pair`

## Requirements
- R1: Coming out of synchronous active-low reset, both queues are empty and all error flags are clear. `status` equals 12'h058 (transmit empty at bit 6, receive empty at bit 4, transmit ready at bit 3) and `flush_busy` is 0.
- R2: An accepted `host_push` appends the four bytes of `host_wdata` to the transmit queue, byte 0 (bits 7:0) first. `tx_byte` always shows the oldest transmit byte. `tx_pop` removes that byte.
- R3: A `host_push` made while the transmit queue has fewer than four free bytes is dropped whole. It sets the sticky transmit overflow flag, `status` bit 11.
- R4: A `tx_pop` on an empty transmit queue presents `tx_byte` = 0. It changes no stored byte and sets the sticky transmit underflow flag, `status` bit 10.
- R5: `host_rdata` lane i (bits 8i+7:8i) shows the i-th oldest receive byte, and 0 for lanes at or above the fill level. `host_pop` removes min(fill, 4) bytes.
- R6: An `rx_push` made while the receive queue holds 8 bytes is dropped. It sets the sticky receive overflow flag, `status` bit 9.
- R7: A `host_pop` on an empty receive queue presents `host_rdata` = 0 and sets the sticky receive underflow flag, `status` bit 8.
- R8: `status` bit 7 / bit 6 are transmit full / empty. Bit 5 / bit 4 are receive full / empty. Each queue holds 8 bytes.
- R9: The transmit threshold is `cfg_word[30:28]` and the receive threshold is `cfg_word[26:24]`. `status` bit 3 is 1 when transmit free space > transmit threshold. Bit 2 is 1 when receive fill > receive threshold. No other `cfg_word` bit has any effect.
- R10: `flush_busy` is 1 in the cycle after each cycle in which `flush_req` is sampled 1, and is 0 otherwise. At the end of a busy cycle both queues are empty and all four error flags are clear. Pushes and pops made during the busy cycle are discarded.
- R11: Once set, an error flag stays set through further traffic until a flush or a reset.
- R12: A push and a pop on the same queue in the same cycle both take effect. Acceptance is decided on the fill level before that cycle.
- R13: `status` bits 1 and 0 are always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_word | input | 32 | Configuration word; thresholds at bits 30:28 (transmit) and 26:24 (receive) |
| flush_req | input | 1 | Request to empty both queues |
| host_push | input | 1 | Push one host word into the transmit queue |
| host_wdata | input | 32 | Host word to push, little-endian |
| host_pop | input | 1 | Pop one host word from the receive queue |
| host_rdata | output | 32 | Oldest receive bytes, little-endian, zero beyond fill |
| tx_pop | input | 1 | Shift side removes one transmit byte |
| tx_byte | output | 8 | Oldest transmit byte (0 when empty) |
| rx_push | input | 1 | Shift side appends one receive byte |
| rx_byte | input | 8 | Receive byte to append |
| status | output | 12 | Error, full, empty and ready flags (bits 11..2), bits 1:0 zero |
| flush_busy | output | 1 | Flush in progress; reads 0 once done |

## Verification
The receive path is run from a table of fill counts from one to eight bytes, each paired with its own pair of thresholds. This separates the "exceeds" comparison from an "at least" comparison at the exact boundary. Partial-word fills show whether the upper lanes are zeroed and whether a pop removes only what is present. A fill of eight tells full apart from merely ready.

Directed sequences then cover the transmit byte order, a word push refused for lack of space, and pops from empty queues on both sides. They also cover simultaneous push and pop, flag persistence across traffic, and accesses made during the flush cycle. A configuration word with every unrelated bit set shows that only the two threshold fields matter.

// File: rtl/tfifo_pkg.sv
// Shared constants and types for the threshold FIFO pair.
package tfifo_pkg;
    localparam int FIFO_DEPTH = 8;
    localparam int WORD_BYTES = 4;
    localparam int THR_W      = 3;
    localparam int WTHR_LSB   = 28;
    localparam int RTHR_LSB   = 24;
    localparam int STAT_W     = 12;

    // Status bit positions, decoded by the register neighbour.
    localparam int ST_W_OVF  = 11;
    localparam int ST_W_UNF  = 10;
    localparam int ST_R_OVF  = 9;
    localparam int ST_R_UNF  = 8;
    localparam int ST_W_FULL = 7;
    localparam int ST_W_EMPT = 6;
    localparam int ST_R_FULL = 5;
    localparam int ST_R_EMPT = 4;
    localparam int ST_W_RDY  = 3;
    localparam int ST_R_RDY  = 2;

    // What a ready flag compares against its threshold.
    typedef enum logic {
        FLAG_FILL  = 1'b0,
        FLAG_SPACE = 1'b1
    } flag_mode_e;
endpackage

// File: rtl/tf_byte_fifo.sv
// Circular byte queue whose push width and pop width are both parameters.
// A push moves PUSH_W bytes, and only when that many bytes are free;
// otherwise it is dropped and the overflow flag is set.
// A pop removes up to POP_W bytes, as many as are stored.
// Pop data lanes at or above the fill level read as zero.
// A pop on an empty queue sets the underflow flag.
// Both flags are sticky until clear or reset.
// Assumes DEPTH is a power of two and is at least PUSH_W and POP_W.
module tf_byte_fifo #(
    parameter int DEPTH  = 8,
    parameter int PUSH_W = 4,
    parameter int POP_W  = 1,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = PTR_W + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear,
    input  logic               push,
    input  logic [8*PUSH_W-1:0] push_data,
    input  logic               pop,
    output logic [8*POP_W-1:0] pop_data,
    output logic [CNT_W-1:0]   level,
    output logic               ovf,
    output logic               unf
);
    localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] PUSH_C  = CNT_W'(PUSH_W);
    localparam logic [CNT_W-1:0] POP_C   = CNT_W'(POP_W);

    logic [7:0]       mem [DEPTH];
    logic [PTR_W-1:0] rd_ptr, wr_ptr;
    logic [CNT_W-1:0] level_q, push_cnt, pop_cnt;
    logic             push_ok;

    // Decide what this cycle's push and pop actually move.
    always_comb begin
        push_ok  = push && ((DEPTH_C - level_q) >= PUSH_C);
        push_cnt = push_ok ? PUSH_C : '0;
        if (!pop)                  pop_cnt = '0;
        else if (level_q >= POP_C) pop_cnt = POP_C;
        else                       pop_cnt = level_q;
    end

    // Present the oldest bytes, zero beyond the fill level.
    for (genvar g = 0; g < POP_W; g++) begin : g_lane
        logic [PTR_W-1:0] idx;
        assign idx = rd_ptr + PTR_W'(g);
        assign pop_data[8*g +: 8] = (level_q > CNT_W'(g)) ? mem[idx] : 8'h00;
    end

    // Store accepted push bytes, lowest lane first.
    always_ff @(posedge clk) begin
        if (!clear && push_ok) begin
            for (int j = 0; j < PUSH_W; j++) begin
                mem[wr_ptr + PTR_W'(j)] <= push_data[8*j +: 8];
            end
        end
    end

    // Advance the pointers and the fill level.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            rd_ptr  <= '0;
            wr_ptr  <= '0;
            level_q <= '0;
        end else begin
            rd_ptr  <= rd_ptr + pop_cnt[PTR_W-1:0];
            wr_ptr  <= wr_ptr + push_cnt[PTR_W-1:0];
            level_q <= level_q - pop_cnt + push_cnt;
        end
    end

    // Keep the sticky error flags.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            ovf <= 1'b0;
            unf <= 1'b0;
        end else begin
            ovf <= ovf | (push && !push_ok);
            unf <= unf | (pop && (level_q == '0));
        end
    end

    assign level = level_q;
endmodule

// File: rtl/tf_fifo_flags.sv
// Full, empty and ready flags for one queue.
// In FLAG_FILL mode, ready means the fill level exceeds the threshold.
// In FLAG_SPACE mode, ready means the free space exceeds the threshold.
// Assumes level never exceeds DEPTH.
module tf_fifo_flags #(
    parameter int DEPTH = 8,
    parameter int THR_W = 3,
    parameter tfifo_pkg::flag_mode_e MODE = tfifo_pkg::FLAG_FILL,
    localparam int CNT_W = $clog2(DEPTH) + 1
) (
    input  logic [CNT_W-1:0] level,
    input  logic [THR_W-1:0] thr,
    output logic             full,
    output logic             empty,
    output logic             ready
);
    localparam int CMP_W = CNT_W + THR_W;
    localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

    logic [CNT_W-1:0] basis;

    // Pick the quantity the threshold is compared with.
    if (MODE == tfifo_pkg::FLAG_SPACE) begin : g_space
        assign basis = DEPTH_C - level;
    end else begin : g_fill
        assign basis = level;
    end

    // Derive the three flags.
    always_comb begin
        full  = (level == DEPTH_C);
        empty = (level == '0);
        ready = CMP_W'(basis) > CMP_W'(thr);
    end
endmodule

// File: rtl/tf_flush_ctl.sv
// Self-clearing flush sequencer. A sampled request raises busy for the
// next cycle. The queues are cleared at the end of that cycle, so busy
// reads back low once the flush is done. Assumes the request is a pulse
// from a register write; a held request simply keeps flushing.
module tf_flush_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic flush_req,
    output logic busy
);
    // Register the request into the one-cycle busy window.
    always_ff @(posedge clk) begin
        if (!rst_n) busy <= 1'b0;
        else        busy <= flush_req;
    end
endmodule

// File: rtl/thr_fifo_pair.sv
// Transmit and receive byte queues between a 32-bit host port and a byte
// wide shift engine. The transmit queue takes host words and gives bytes.
// The receive queue takes bytes and gives host words. Thresholds come from
// the configuration word; the status word collects the flags of both queues.
// Assumes a single clock domain for host and shift sides.
module thr_fifo_pair
    import tfifo_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [31:0] cfg_word,
    input  logic        flush_req,
    input  logic        host_push,
    input  logic [31:0] host_wdata,
    input  logic        host_pop,
    output logic [31:0] host_rdata,
    input  logic        tx_pop,
    output logic [7:0]  tx_byte,
    input  logic        rx_push,
    input  logic [7:0]  rx_byte,
    output logic [11:0] status,
    output logic        flush_busy
);
    localparam int CNT_W = $clog2(FIFO_DEPTH) + 1;

    logic [THR_W-1:0] w_thr, r_thr;
    logic [CNT_W-1:0] w_level, r_level;
    logic w_ovf, w_unf, r_ovf, r_unf;
    logic w_full, w_empty, w_ready, r_full, r_empty, r_ready;
    logic clear;
    logic unused_cfg;

    // Decode the two threshold fields; the other bits are ignored.
    assign w_thr      = cfg_word[WTHR_LSB +: THR_W];
    assign r_thr      = cfg_word[RTHR_LSB +: THR_W];
    assign unused_cfg = ^{cfg_word[31], cfg_word[27], cfg_word[23:0]};

    tf_flush_ctl u_flush (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush_req (flush_req),
        .busy      (clear)
    );

    tf_byte_fifo #(.DEPTH(FIFO_DEPTH), .PUSH_W(WORD_BYTES), .POP_W(1)) u_txq (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (clear),
        .push      (host_push),
        .push_data (host_wdata),
        .pop       (tx_pop),
        .pop_data  (tx_byte),
        .level     (w_level),
        .ovf       (w_ovf),
        .unf       (w_unf)
    );

    tf_byte_fifo #(.DEPTH(FIFO_DEPTH), .PUSH_W(1), .POP_W(WORD_BYTES)) u_rxq (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (clear),
        .push      (rx_push),
        .push_data (rx_byte),
        .pop       (host_pop),
        .pop_data  (host_rdata),
        .level     (r_level),
        .ovf       (r_ovf),
        .unf       (r_unf)
    );

    tf_fifo_flags #(.DEPTH(FIFO_DEPTH), .THR_W(THR_W), .MODE(FLAG_SPACE)) u_txflags (
        .level (w_level),
        .thr   (w_thr),
        .full  (w_full),
        .empty (w_empty),
        .ready (w_ready)
    );

    tf_fifo_flags #(.DEPTH(FIFO_DEPTH), .THR_W(THR_W), .MODE(FLAG_FILL)) u_rxflags (
        .level (r_level),
        .thr   (r_thr),
        .full  (r_full),
        .empty (r_empty),
        .ready (r_ready)
    );

    // Pack the status word in the neighbour's bit order.
    always_comb begin
        status            = '0;
        status[ST_W_OVF]  = w_ovf;
        status[ST_W_UNF]  = w_unf;
        status[ST_R_OVF]  = r_ovf;
        status[ST_R_UNF]  = r_unf;
        status[ST_W_FULL] = w_full;
        status[ST_W_EMPT] = w_empty;
        status[ST_R_FULL] = r_full;
        status[ST_R_EMPT] = r_empty;
        status[ST_W_RDY]  = w_ready;
        status[ST_R_RDY]  = r_ready;
    end

    assign flush_busy = clear;
endmodule

// File: rtl/thr_fifo_pair_chk.sv
// Port-level checker for thr_fifo_pair, attached with bind below.
module thr_fifo_pair_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] cfg_word,
    input logic        flush_req,
    input logic        host_push,
    input logic [31:0] host_wdata,
    input logic        host_pop,
    input logic [31:0] host_rdata,
    input logic        tx_pop,
    input logic [7:0]  tx_byte,
    input logic        rx_push,
    input logic [7:0]  rx_byte,
    input logic [11:0] status,
    input logic        flush_busy
);
    // R3: push into a full transmit queue raises overflow
    a_r3_push_full_ovf: assert property (@(posedge clk) disable iff (!rst_n)
        host_push && status[7] && !flush_busy |=> status[11]);

    // R4: pop from empty transmit queue yields zero
    a_r4_tx_empty_zero: assert property (@(posedge clk) disable iff (!rst_n)
        status[6] |-> tx_byte == 8'h00);

    // R6: byte push into a full receive queue raises overflow
    a_r6_rx_full_ovf: assert property (@(posedge clk) disable iff (!rst_n)
        rx_push && status[5] && !flush_busy |=> status[9]);

    // R7: pop from empty receive queue yields zero and raises underflow
    a_r7_rx_empty_unf: assert property (@(posedge clk) disable iff (!rst_n)
        host_pop && status[4] && !flush_busy |=> status[8]);
    a_r7_rx_empty_zero: assert property (@(posedge clk) disable iff (!rst_n)
        status[4] |-> host_rdata == 32'h0);

    // R8: a queue is never both full and empty
    a_r8_full_empty: assert property (@(posedge clk) disable iff (!rst_n)
        !(status[7] && status[6]) && !(status[5] && status[4]));

    // R10: busy only follows a request, and a flush leaves everything clean
    a_r10_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !flush_req |=> !flush_busy);
    a_r10_flush_clean: assert property (@(posedge clk) disable iff (!rst_n)
        flush_busy |=> status[11:8] == 4'h0 && status[6] && status[4]);

    // R11: error flags persist while no flush is running
    a_r11_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !flush_busy |=> (status[11:8] & $past(status[11:8])) == $past(status[11:8]));

    // R12: a byte push always leaves the receive queue non-empty
    a_r12_rx_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
        rx_push && !flush_busy |=> !status[4]);

    // R13: reserved status bits stay zero
    a_r13_low_bits: assert property (@(posedge clk) disable iff (!rst_n)
        status[1:0] == 2'b00);
endmodule

bind thr_fifo_pair thr_fifo_pair_chk u_chk (.*);

// File: tb/tb_thr_fifo_pair.sv
module tb_thr_fifo_pair;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] cfg_word = '0;
    logic        flush_req = 1'b0;
    logic        host_push = 1'b0;
    logic [31:0] host_wdata = '0;
    logic        host_pop = 1'b0;
    logic [31:0] host_rdata;
    logic        tx_pop = 1'b0;
    logic [7:0]  tx_byte;
    logic        rx_push = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic [11:0] status;
    logic        flush_busy;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    thr_fifo_pair dut (.*);

    // Table: {fill count[3:0], receive threshold[2:0], transmit threshold[2:0]}
    localparam logic [9:0] VEC [8] = '{
        {4'd1, 3'd0, 3'd3}, {4'd1, 3'd1, 3'd4}, {4'd3, 3'd2, 3'd0},
        {4'd4, 3'd4, 3'd7}, {4'd5, 3'd4, 3'd3}, {4'd7, 3'd6, 3'd2},
        {4'd8, 3'd7, 3'd5}, {4'd6, 3'd6, 3'd6}
    };

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_word(input int base, input int cnt);
        logic [31:0] w = '0;
        for (int i = 0; i < 4; i++)
            if (i < cnt) w[8*i +: 8] = 8'(base + i);
        return w;
    endfunction

    task automatic do_flush();
        flush_req = 1'b1; tick(); flush_req = 1'b0; tick();
    endtask

    task automatic push_rx(input logic [7:0] b);
        rx_push = 1'b1; rx_byte = b; tick(); rx_push = 1'b0;
    endtask

    task automatic push_host(input logic [31:0] w);
        host_push = 1'b1; host_wdata = w; tick(); host_push = 1'b0;
    endtask

    task automatic pop_tx();
        tx_pop = 1'b1; tick(); tx_pop = 1'b0;
    endtask

    task automatic pop_host();
        host_pop = 1'b1; tick(); host_pop = 1'b0;
    endtask

    initial begin
        #2000000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #1;
        tick(); tick();
        rst_n = 1'b1;
        tick();
        // R1 / R13: reset state
        chk("R1 status after reset", 32'(status), 32'h058);
        chk("R1 flush_busy after reset", 32'(flush_busy), 32'h0);
        chk("R13 low status bits", 32'(status[1:0]), 32'h0);

        // R5 / R8 / R9: table of receive fills and thresholds
        foreach (VEC[k]) begin
            int n  = int'(VEC[k][9:6]);
            int rt = int'(VEC[k][5:3]);
            int wt = int'(VEC[k][2:0]);
            cfg_word = {1'b0, 3'(wt), 1'b0, 3'(rt), 24'h0};
            do_flush();
            for (int i = 0; i < n; i++) push_rx(8'(8'hA0 + i));
            chk("R9 receive ready vs threshold", 32'(status[2]), 32'(n > rt));
            chk("R8 receive full", 32'(status[5]), 32'(n == 8));
            chk("R8 receive empty", 32'(status[4]), 32'h0);
            push_host(32'h0403_0201);
            chk("R9 transmit ready vs threshold", 32'(status[3]), 32'(4 > wt));
            chk("R5 first word lanes", host_rdata, exp_word(8'hA0, n));
            pop_host();
            chk("R5 second word lanes", host_rdata, exp_word(8'hA4, (n > 4) ? n - 4 : 0));
            if (n > 4) pop_host();
            chk("R5 receive empty after pops", 32'(status[4]), 32'h1);
        end

        // R2 / R12: transmit byte order and simultaneous push and pop
        cfg_word = {1'b0, 3'd3, 1'b0, 3'd0, 24'h0};
        do_flush();
        push_host(32'h4433_2211);
        chk("R2 first transmit byte", 32'(tx_byte), 32'h11);
        host_push = 1'b1; host_wdata = 32'h8877_6655; tx_pop = 1'b1;
        tick();
        host_push = 1'b0; tx_pop = 1'b0;
        chk("R12 byte after concurrent push/pop", 32'(tx_byte), 32'h22);
        chk("R12 not full at seven bytes", 32'(status[7]), 32'h0);
        for (int i = 0; i < 6; i++) pop_tx();
        chk("R2 last transmit byte", 32'(tx_byte), 32'h88);
        pop_tx();
        chk("R8 transmit empty after drain", 32'(status[6]), 32'h1);

        // R3 / R11: refused word push
        push_host(32'h4433_2211);
        push_host(32'h8877_6655);
        chk("R8 transmit full", 32'(status[7]), 32'h1);
        chk("R3 no overflow before refusal", 32'(status[11]), 32'h0);
        push_host(32'hDEAD_BEEF);
        chk("R3 overflow set", 32'(status[11]), 32'h1);
        for (int i = 0; i < 7; i++) pop_tx();
        chk("R3 refused word not stored", 32'(tx_byte), 32'h88);
        pop_tx();
        chk("R3 queue empty after eight bytes", 32'(status[6]), 32'h1);
        chk("R11 overflow still set", 32'(status[11]), 32'h1);

        // R4: transmit pop on empty
        chk("R4 empty transmit byte is zero", 32'(tx_byte), 32'h0);
        pop_tx();
        chk("R4 transmit underflow set", 32'(status[10]), 32'h1);
        chk("R4 still empty", 32'(status[6]), 32'h1);

        // R6 / R7: receive overflow and underflow
        do_flush();
        chk("R7 empty receive word is zero", host_rdata, 32'h0);
        pop_host();
        chk("R7 receive underflow set", 32'(status[8]), 32'h1);
        for (int i = 0; i < 9; i++) push_rx(8'(8'h10 + i));
        chk("R6 receive overflow set", 32'(status[9]), 32'h1);
        pop_host(); pop_host();
        chk("R6 ninth byte dropped", 32'(status[4]), 32'h1);
        chk("R11 underflow still set", 32'(status[8]), 32'h1);

        // R10: flush clears flags; accesses in busy cycle discarded
        flush_req = 1'b1; tick(); flush_req = 1'b0;
        chk("R10 busy after request", 32'(flush_busy), 32'h1);
        host_push = 1'b1; host_wdata = 32'h1234_5678; rx_push = 1'b1; rx_byte = 8'h5A;
        tick();
        host_push = 1'b0; rx_push = 1'b0;
        chk("R10 busy self-clears", 32'(flush_busy), 32'h0);
        chk("R10 status clean after flush", 32'(status), 32'h058);

        // R9: unrelated configuration bits have no effect
        cfg_word = 32'hC9FF_FFFF;
        push_rx(8'h01);
        chk("R9 fill 1 not above threshold 1", 32'(status[2]), 32'h0);
        push_rx(8'h02);
        chk("R9 fill 2 above threshold 1", 32'(status[2]), 32'h1);
        push_host(32'h0);
        chk("R9 space 4 not above threshold 4", 32'(status[3]), 32'h0);
        chk("R13 low bits with all cfg set", 32'(status[1:0]), 32'h0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule